// File: doc/BRIEF.md
# Charge-Transfer Pulse Generator with Spread Spectrum

This block produces the repeating two-phase pulse that drives a capacitive touch acquisition. In every pulse the output first goes high, charging the sense electrode, and then goes low, moving that charge onto the sampling capacitor. The base high and low lengths are programmed in periods of a pulse-generator clock. When spread spectrum is switched on, each high phase is lengthened by a number of periods of a slower spread-spectrum clock. That number follows a triangular sweep, which spreads the emitted energy over a band of frequencies.

Both clocks reach the block as single-cycle enable strobes on one system clock. A start request latches the four configuration fields and begins pulsing. From then on the configuration inputs are ignored until the acquisition ends. A stop request lets the pulse in progress finish and then returns the block to idle, with the output low. A one-cycle end-of-cycle strobe marks the last system cycle of every low phase.

Top module: `charge_pulse_gen`

## Requirements
- R1: After reset, and whenever no acquisition runs, `phase` is 0 (idle), `pulseOut` is 0 and `cycleEnd` is 0. An acquisition begins only after a cycle in which `startReq` was high while idle.
- R2: The high phase (`phase` = 1) spans exactly `cfgHighLen`+1 `pgTick` strobes. The strobe that completes it is the last one seen in that phase.
- R3: The low phase (`phase` = 3) spans exactly `cfgLowLen`+1 `pgTick` strobes. It is always entered from the high phase or the extension phase, and it is left only at a `cycleEnd`.
- R4: With the latched spread enable at 0, no extension phase appears and the high phase is followed directly by the low phase.
- R5: With the latched spread enable at 1, an extension phase (`phase` = 2) lies between the high and low phases. It spans exactly S+1 `ssTick` strobes, where S is the current sweep value.
- R6: The sweep value S is 0 for the first pulse of an acquisition. After each pulse it steps by one, rising to the latched deviation D and then falling back to 0, repeatedly, for example 0,1,2,1,0,1 for D=2. When D is 0 it stays at 0.
- R7: The configuration inputs are sampled in the cycle the acquisition starts. Later changes to them have no effect until the acquisition ends.
- R8: `cycleEnd` is high for exactly one system cycle per pulse. That cycle is the one carrying the `pgTick` that completes the low phase.
- R9: A `stopReq` that arrives during an acquisition, or in the same cycle as a `cycleEnd`, makes that pulse the last one, after which the block is idle. A `stopReq` given together with an accepted `startReq` yields exactly one pulse.
- R10: `startReq` has no effect while an acquisition is running. The sweep and the pulse lengths continue undisturbed.
- R11: `pulseOut` is 1 exactly when `phase` is 1 or 2, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pgTick | input | 1 | Pulse-generator clock enable strobe |
| ssTick | input | 1 | Spread-spectrum clock enable strobe |
| cfgHighLen | input | HIGH_W (4) | High phase length minus one, in pgTick periods |
| cfgLowLen | input | LOW_W (4) | Low phase length minus one, in pgTick periods |
| cfgSpreadDev | input | DEV_W (7) | Peak sweep value D |
| cfgSpreadEn | input | 1 | Spread spectrum on |
| startReq | input | 1 | Begin an acquisition (honoured when idle) |
| stopReq | input | 1 | End the acquisition after the current pulse |
| pulseOut | output | 1 | Charge-transfer pulse level |
| phase | output | 2 | 0 idle, 1 high, 2 extension, 3 low |
| cycleEnd | output | 1 | Last cycle of a low phase |

## Verification
Two events can land in the same system cycle: the end of a pulse, with `cycleEnd` and the sweep step, and a stop request. A second pair is a start request together with a stop request. The bench raises `stopReq` in the exact cycle where it sees `cycleEnd`, and separately raises it together with `startReq`. In both cases it judges the result by the number of pulses counted before `phase` returns to idle, which must equal the requested count. Every pulse of the near-exhaustive sweep of lengths and deviations is also checked for tick counts per phase against arithmetic expectations and against an independent model of the triangular sweep.

// File: rtl/ctpg_pkg.sv
package ctpg_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HIGH = 2'd1,
    PH_EXT  = 2'd2,
    PH_LOW  = 2'd3
  } phase_e;

  // control -> datapath strobes
  typedef struct packed {
    logic loadCfg;
    logic clrCnt;
    logic stepSweep;
  } ctrlStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic hiDone;
    logic extDone;
    logic loDone;
    logic spreadOn;
  } dpStatus_t;

endpackage

// File: rtl/ctpg_datapath.sv
module ctpg_datapath
  import ctpg_pkg::*;
#(
  parameter int HIGH_W = 4,
  parameter int LOW_W  = 4,
  parameter int DEV_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pgTick,
  input  logic              ssTick,
  input  logic [HIGH_W-1:0] cfgHighLen,
  input  logic [LOW_W-1:0]  cfgLowLen,
  input  logic [DEV_W-1:0]  cfgSpreadDev,
  input  logic              cfgSpreadEn,
  input  phase_e            phase,
  input  ctrlStrobe_t       strobe,
  output dpStatus_t         status
);

  localparam int BASE_W = (HIGH_W > LOW_W) ? HIGH_W : LOW_W;
  localparam int CNT_W  = (BASE_W > DEV_W) ? BASE_W : DEV_W;

  logic [HIGH_W-1:0] hiLenQ;
  logic [LOW_W-1:0]  loLenQ;
  logic [DEV_W-1:0]  devQ;
  logic              spreadEnQ;
  logic [CNT_W-1:0]  phaseCnt;
  logic [DEV_W-1:0]  sweepQ;
  logic              sweepUp;
  logic              cntStep;

  // configuration frozen at start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiLenQ    <= '0;
      loLenQ    <= '0;
      devQ      <= '0;
      spreadEnQ <= 1'b0;
    end else if (strobe.loadCfg) begin
      hiLenQ    <= cfgHighLen;
      loLenQ    <= cfgLowLen;
      devQ      <= cfgSpreadDev;
      spreadEnQ <= cfgSpreadEn;
    end
  end

  // one counter shared by all phases; the tick source depends on the phase
  always_comb begin
    unique case (phase)
      PH_HIGH, PH_LOW: cntStep = pgTick;
      PH_EXT:          cntStep = ssTick;
      default:         cntStep = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (strobe.clrCnt) begin
      phaseCnt <= '0;
    end else if (cntStep) begin
      phaseCnt <= phaseCnt + CNT_W'(1);
    end
  end

  // triangular sweep 0..devQ, one step per pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sweepQ  <= '0;
      sweepUp <= 1'b1;
    end else if (strobe.loadCfg) begin
      sweepQ  <= '0;
      sweepUp <= 1'b1;
    end else if (strobe.stepSweep && spreadEnQ) begin
      if (sweepUp) begin
        if (sweepQ == devQ) begin
          sweepUp <= 1'b0;
          sweepQ  <= (devQ == '0) ? '0 : sweepQ - DEV_W'(1);
        end else begin
          sweepQ  <= sweepQ + DEV_W'(1);
        end
      end else begin
        if (sweepQ == '0) begin
          sweepUp <= 1'b1;
          sweepQ  <= (devQ == '0) ? '0 : DEV_W'(1);
        end else begin
          sweepQ  <= sweepQ - DEV_W'(1);
        end
      end
    end
  end

  always_comb begin
    status.hiDone   = (phase == PH_HIGH) && pgTick && (phaseCnt == CNT_W'(hiLenQ));
    status.extDone  = (phase == PH_EXT)  && ssTick && (phaseCnt == CNT_W'(sweepQ));
    status.loDone   = (phase == PH_LOW)  && pgTick && (phaseCnt == CNT_W'(loLenQ));
    status.spreadOn = spreadEnQ;
  end

endmodule

// File: rtl/ctpg_ctrl.sv
module ctpg_ctrl
  import ctpg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        stopReq,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output phase_e      phaseQ,
  output logic        pulseOut,
  output logic        cycleEnd
);

  phase_e phaseD;
  logic   stopPending;

  always_comb begin
    phaseD   = phaseQ;
    strobe   = '0;
    cycleEnd = 1'b0;
    unique case (phaseQ)
      PH_IDLE: begin
        if (startReq) begin
          phaseD         = PH_HIGH;
          strobe.loadCfg = 1'b1;
          strobe.clrCnt  = 1'b1;
        end
      end
      PH_HIGH: begin
        if (status.hiDone) begin
          phaseD        = status.spreadOn ? PH_EXT : PH_LOW;
          strobe.clrCnt = 1'b1;
        end
      end
      PH_EXT: begin
        if (status.extDone) begin
          phaseD        = PH_LOW;
          strobe.clrCnt = 1'b1;
        end
      end
      PH_LOW: begin
        if (status.loDone) begin
          cycleEnd         = 1'b1;
          strobe.stepSweep = 1'b1;
          strobe.clrCnt    = 1'b1;
          phaseD           = (stopPending || stopReq) ? PH_IDLE : PH_HIGH;
        end
      end
      default: phaseD = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ      <= PH_IDLE;
      stopPending <= 1'b0;
    end else begin
      phaseQ <= phaseD;
      if (phaseQ == PH_IDLE) begin
        stopPending <= startReq && stopReq;
      end else begin
        stopPending <= stopPending || stopReq;
      end
    end
  end

  assign pulseOut = (phaseQ == PH_HIGH) || (phaseQ == PH_EXT);

endmodule

// File: rtl/charge_pulse_gen.sv
module charge_pulse_gen
  import ctpg_pkg::*;
#(
  parameter int HIGH_W = 4,
  parameter int LOW_W  = 4,
  parameter int DEV_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pgTick,
  input  logic              ssTick,
  input  logic [HIGH_W-1:0] cfgHighLen,
  input  logic [LOW_W-1:0]  cfgLowLen,
  input  logic [DEV_W-1:0]  cfgSpreadDev,
  input  logic              cfgSpreadEn,
  input  logic              startReq,
  input  logic              stopReq,
  output logic              pulseOut,
  output logic [1:0]        phase,
  output logic              cycleEnd
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;
  phase_e      phaseQ;

  ctpg_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .stopReq  (stopReq),
    .status   (status),
    .strobe   (strobe),
    .phaseQ   (phaseQ),
    .pulseOut (pulseOut),
    .cycleEnd (cycleEnd)
  );

  ctpg_datapath #(
    .HIGH_W (HIGH_W),
    .LOW_W  (LOW_W),
    .DEV_W  (DEV_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .pgTick       (pgTick),
    .ssTick       (ssTick),
    .cfgHighLen   (cfgHighLen),
    .cfgLowLen    (cfgLowLen),
    .cfgSpreadDev (cfgSpreadDev),
    .cfgSpreadEn  (cfgSpreadEn),
    .phase        (phaseQ),
    .strobe       (strobe),
    .status       (status)
  );

  assign phase = phaseQ;

endmodule

// File: rtl/ctpg_checker.sv
module ctpg_checker (
  input logic       clk,
  input logic       rstN,
  input logic       pgTick,
  input logic       ssTick,
  input logic       startReq,
  input logic       stopReq,
  input logic       pulseOut,
  input logic [1:0] phase,
  input logic       cycleEnd
);

  assert_idle_low_R11: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 2'd0) |-> !pulseOut);

  assert_start_from_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 2'd1 && $past(phase) == 2'd0) |-> $past(startReq));

  assert_high_waits_tick_R2: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 2'd1 && !pgTick) |=> (phase == 2'd1));

  assert_ext_waits_tick_R5: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 2'd2 && !ssTick) |=> (phase == 2'd2));

  assert_low_entry_R3: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 2'd3 && $past(phase) != 2'd3) |-> ($past(phase) == 2'd1 || $past(phase) == 2'd2));

  assert_low_exit_R3: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 2'd3 && !cycleEnd) |=> (phase == 2'd3));

  assert_end_on_tick_R8: assert property (@(posedge clk) disable iff (!rstN)
    cycleEnd |-> (pgTick && phase == 2'd3));

  assert_end_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    cycleEnd |=> !cycleEnd);

  assert_stop_at_end_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cycleEnd && stopReq) |=> (phase == 2'd0));

endmodule

bind charge_pulse_gen ctpg_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .pgTick   (pgTick),
  .ssTick   (ssTick),
  .startReq (startReq),
  .stopReq  (stopReq),
  .pulseOut (pulseOut),
  .phase    (phase),
  .cycleEnd (cycleEnd)
);

// File: tb/charge_pulse_gen_tb.sv
module charge_pulse_gen_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic       pgTick, ssTick;
  logic [3:0] cfgHighLen, cfgLowLen;
  logic [6:0] cfgSpreadDev;
  logic       cfgSpreadEn;
  logic       startReq, stopReq;
  logic       pulseOut;
  logic [1:0] phase;
  logic       cycleEnd;

  int  nChecks = 0;
  int  nFails  = 0;
  int  cyc     = 0;
  int  pgDiv   = 1;
  int  ssDiv   = 1;
  bit  finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  charge_pulse_gen u_dut (
    .clk          (clk),
    .rstN         (rstN),
    .pgTick       (pgTick),
    .ssTick       (ssTick),
    .cfgHighLen   (cfgHighLen),
    .cfgLowLen    (cfgLowLen),
    .cfgSpreadDev (cfgSpreadDev),
    .cfgSpreadEn  (cfgSpreadEn),
    .startReq     (startReq),
    .stopReq      (stopReq),
    .pulseOut     (pulseOut),
    .phase        (phase),
    .cycleEnd     (cycleEnd)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic driveTicks();
    pgTick = (cyc % pgDiv) == 0;
    ssTick = (cyc % ssDiv) == 0;
    cyc++;
  endtask

  // one acquisition; stop raised in the cycle of the last cycleEnd
  task automatic runAcq(int hi, int lo, int dev, bit en, int nPulses,
                        int pd, int sd, bit scramble, bit pokeStart, bit stopWithStart);
    int sw = 0;
    bit up = 1'b1;
    int hiT = 0, extT = 0, loT = 0, ends = 0, badEnd = 0, levelBad = 0;
    int pulses = 0;
    int guard = 0;
    pgDiv = pd;
    ssDiv = sd;
    @(negedge clk);
    cfgHighLen   = 4'(hi);
    cfgLowLen    = 4'(lo);
    cfgSpreadDev = 7'(dev);
    cfgSpreadEn  = en;
    startReq     = 1'b1;
    stopReq      = stopWithStart;
    driveTicks();
    forever begin
      @(negedge clk);
      startReq = pokeStart && (pulses < nPulses) && (cyc % 7 == 0);
      stopReq  = 1'b0;
      if (scramble) begin
        cfgHighLen   = 4'(cyc * 5);
        cfgLowLen    = 4'(cyc * 3 + 1);
        cfgSpreadDev = 7'(cyc * 11);
        cfgSpreadEn  = cyc[1];
      end
      driveTicks();
      #1;
      guard++;
      if (phase == 2'd0 || guard > 60000 || pulses > nPulses) break;
      if (phase == 2'd1 && pgTick) hiT++;
      if (phase == 2'd2 && ssTick) extT++;
      if (phase == 2'd3 && pgTick) loT++;
      if (pulseOut != (phase == 2'd1 || phase == 2'd2)) levelBad++;
      if (cycleEnd) begin
        ends++;
        if (!(pgTick && phase == 2'd3)) badEnd++;
        // pulse complete: judge it
        check(hiT == hi + 1, "R2/R7", "high-phase pgTicks", hiT, hi + 1);
        if (en) check(extT == sw + 1, "R5/R6", "extension ssTicks", extT, sw + 1);
        else    check(extT == 0, "R4", "extension ssTicks with spread off", extT, 0);
        check(loT == lo + 1, "R3/R7", "low-phase pgTicks", loT, lo + 1);
        check(ends == 1 && badEnd == 0, "R8", "cycleEnd strobes in pulse", ends, 1);
        check(levelBad == 0, "R11", "pulseOut level mismatches", levelBad, 0);
        hiT = 0; extT = 0; loT = 0; ends = 0; badEnd = 0; levelBad = 0;
        pulses++;
        if (en) begin
          if (up) begin
            if (sw == dev) begin up = 1'b0; sw = (dev == 0) ? 0 : sw - 1; end
            else sw++;
          end else begin
            if (sw == 0) begin up = 1'b1; sw = (dev == 0) ? 0 : 1; end
            else sw--;
          end
        end
        if (pulses == nPulses && !stopWithStart) stopReq = 1'b1;
      end
    end
    check(pulses == nPulses, pokeStart ? "R9/R10" : "R9", "pulses before idle", pulses, nPulses);
    check(phase == 2'd0 && !pulseOut, "R1", "idle after acquisition", int'(phase), 0);
  endtask

  initial begin
    rstN = 1'b0;
    pgTick = 1'b0; ssTick = 1'b0;
    cfgHighLen = '0; cfgLowLen = '0; cfgSpreadDev = '0; cfgSpreadEn = 1'b0;
    startReq = 1'b0; stopReq = 1'b0;
    repeat (3) @(negedge clk);
    check(phase == 2'd0 && !pulseOut && !cycleEnd, "R1", "state during reset", int'(phase), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(phase == 2'd0 && !pulseOut && !cycleEnd, "R1", "state after reset", int'(phase), 0);

    // exhaustive base lengths, spread off; some with stop alongside start (R9)
    for (int h = 0; h < 16; h++) begin
      for (int l = 0; l < 16; l++) begin
        if ((h + l) % 3 == 0) runAcq(h, l, 0, 1'b0, 1, 1, 1, 1'b0, 1'b0, 1'b1);
        else                  runAcq(h, l, 0, 1'b0, 1, 1, 1, 1'b0, 1'b0, 1'b0);
      end
    end

    // slower tick strobes, several pulses
    runAcq(3, 7, 0, 1'b0, 4, 3, 1, 1'b0, 1'b0, 1'b0);
    runAcq(15, 0, 0, 1'b0, 3, 2, 1, 1'b0, 1'b0, 1'b0);
    // spread off although a deviation is given (R4)
    runAcq(2, 2, 50, 1'b0, 3, 1, 1, 1'b0, 1'b0, 1'b0);

    // spread on, several deviations, full triangle cycles (R5, R6)
    runAcq(1, 1, 0, 1'b1, 4, 1, 1, 1'b0, 1'b0, 1'b0);
    runAcq(0, 0, 1, 1'b1, 5, 1, 2, 1'b0, 1'b0, 1'b0);
    runAcq(4, 2, 2, 1'b1, 7, 2, 3, 1'b0, 1'b0, 1'b0);
    runAcq(1, 3, 3, 1'b1, 9, 1, 2, 1'b0, 1'b0, 1'b0);
    runAcq(6, 5, 6, 1'b1, 15, 1, 1, 1'b0, 1'b0, 1'b0);
    runAcq(2, 1, 127, 1'b1, 257, 1, 1, 1'b0, 1'b0, 1'b0);

    // inputs scrambled and start poked while running (R7, R10)
    runAcq(5, 9, 5, 1'b1, 12, 1, 2, 1'b1, 1'b1, 1'b0);
    runAcq(0, 15, 0, 1'b0, 6, 2, 1, 1'b1, 1'b1, 1'b0);

    // one-pulse acquisition with spread on and stop together with start (R9)
    runAcq(3, 3, 4, 1'b1, 1, 1, 1, 1'b0, 1'b0, 1'b1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", 200000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule